// File: doc/BRIEF.md
# Bit-Clearing Program-Once Memory Emulator

This block is a synthesizable stand-in for a 4096-word by 8-bit memory. Once cleared, the memory can only have bits pulled from 1 to 0. Two control lines govern it: an active-low chip enable (`ce_n`) and an active-low output enable (`oe_n`). The output-enable line also carries a high-voltage programming state, which the block receives as the digital flag `vpp_high`. From these three levels the block decodes one of five modes: standby, read (also used for verify), output quiet, program and program inhibit. It then either gates the addressed word onto the data bus or takes a byte from the bus to program.

A program operation is a low pulse on `ce_n` that begins while `vpp_high` is set. The block counts the pulse length in clock cycles. On the rising edge of `ce_n` it commits the write only if the count falls inside a window of 45 ms to 55 ms, worked out from the clock-frequency parameter. A pulse outside the window is dropped and raises a one-cycle error flag. The tri-state byte bus is split into `din`, `dout` and `dout_en`. A synchronous `erase` input sets every cell back to all ones.

Top module: `eprom_emu`

## Requirements
- R1: After reset, or in the cycle after `erase` is sampled high, every address reads 8'hFF. Erase takes priority over a program commit that lands on the same edge.
- R2: A committed program leaves the addressed word equal to the old word ANDed with the applied byte. A 1 in the applied byte never sets a cell.
- R3: With `ce_n` high, `dout_en` is 0 whatever the levels of `oe_n` and `vpp_high`.
- R4: With `ce_n`=0, `oe_n`=0 and `vpp_high`=0, `dout_en` is 1 and `dout` equals the stored word at `addr`, with no clock delay.
- R5: With `ce_n`=0, `oe_n`=1 and `vpp_high`=0, `dout_en` is 0.
- R6: While `vpp_high` is 1, `dout_en` is 0. With `ce_n` held high, no cell changes (program inhibit).
- R7: A pulse is armed only by a falling `ce_n` sampled while `vpp_high` is 1. Its length N is the number of clock edges at which `ce_n` is sampled low. The address and byte are captured at the first of those edges. The write commits only if MIN ≤ N ≤ MAX, where MIN = CLK_HZ·45/1000 and MAX = CLK_HZ·55/1000 cycles.
- R8: A pulse that ends with N outside the window causes no write and drives `prog_err` high for exactly one cycle: the cycle after the edge at which `ce_n` is first sampled high again.
- R9: If `ce_n` is already low when `vpp_high` rises, the low level is not a pulse. If `vpp_high` drops during an armed pulse, the pulse is discarded. Neither case writes a cell or raises `prog_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its frequency is the CLK_HZ parameter |
| rst | input | 1 | Synchronous active-high reset; also erases the array |
| erase | input | 1 | Synchronous erase of all cells to ones |
| addr | input | 12 | Word address |
| ce_n | input | 1 | Active-low chip enable and program pulse |
| oe_n | input | 1 | Active-low output enable (logic level) |
| vpp_high | input | 1 | Programming voltage present on the output-enable line |
| din | input | 8 | Byte applied to the bus during programming |
| dout | output | 8 | Stored word at `addr` |
| dout_en | output | 1 | Bus drive enable |
| prog_err | output | 1 | One-cycle flag for a rejected program pulse |

## Verification
The pulse length is probed at MIN−1, MIN, MAX and MAX+1 cycles. Random lengths straddling both window edges then separate a correct comparison from an off-by-one count on either side. Repeated programs of one word with overlapping bit patterns show that the stored word is the AND of all committed bytes and not the last byte written. Control-level sweeps cover standby with output enable low, quiet mode with output enable high, and inhibit with the programming flag set, which keeps the output-gating terms apart. A chip enable that is low before the programming flag rises, and a flag dropped mid-pulse, both show that only a real falling edge under programming voltage can lead to a write.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int EP_ADDR_W = 12;
    localparam int EP_DATA_W = 8;
    localparam int EP_DEPTH  = 1 << EP_ADDR_W;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_QUIET,
        MODE_PROGRAM,
        MODE_INHIBIT
    } mode_e;

    typedef struct packed {
        logic                 valid;
        logic [EP_ADDR_W-1:0] addr;
        logic [EP_DATA_W-1:0] data;
    } wr_req_t;

    function automatic longint ms_to_cycles(input longint hz, input longint ms);
        return (hz * ms) / 1000;
    endfunction

    function automatic mode_e decode_mode(input logic ce_n, input logic oe_n,
                                          input logic vpp);
        mode_e m;
        if (vpp)       m = ce_n ? MODE_INHIBIT : MODE_PROGRAM;
        else if (ce_n) m = MODE_STANDBY;
        else if (oe_n) m = MODE_QUIET;
        else           m = MODE_READ;
        return m;
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_high,
    output mode_e mode,
    output logic  drive
);
    always_comb begin
        mode  = decode_mode(ce_n, oe_n, vpp_high);
        drive = (mode == MODE_READ);
    end
endmodule

// File: rtl/eprom_pulse_qual.sv
module eprom_pulse_qual
    import eprom_pkg::*;
#(
    parameter longint MIN_CYC = 90,
    parameter longint MAX_CYC = 110,
    localparam int    CNT_W   = $clog2(MAX_CYC + 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce_n,
    input  logic                 vpp_high,
    input  logic [EP_ADDR_W-1:0] addr,
    input  logic [EP_DATA_W-1:0] din,
    output wr_req_t              wr_req,
    output logic                 reject
);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CYC);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_CYC + 1);

    logic                 ce_q;
    logic                 armed;
    logic [CNT_W-1:0]     cnt;
    logic [EP_ADDR_W-1:0] cap_addr;
    logic [EP_DATA_W-1:0] cap_data;
    logic                 fall;
    logic                 in_window;

    assign fall      = ce_q & ~ce_n;
    assign in_window = (cnt >= CNT_MIN) && (cnt <= CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q     <= 1'b1;
            armed    <= 1'b0;
            cnt      <= '0;
            cap_addr <= '0;
            cap_data <= '0;
            wr_req   <= '0;
            reject   <= 1'b0;
        end else begin
            ce_q         <= ce_n;
            wr_req.valid <= 1'b0;
            reject       <= 1'b0;
            if (armed) begin
                if (!vpp_high) begin
                    armed <= 1'b0;
                end else if (ce_n) begin
                    armed <= 1'b0;
                    if (in_window) begin
                        wr_req.valid <= 1'b1;
                        wr_req.addr  <= cap_addr;
                        wr_req.data  <= cap_data;
                    end else begin
                        reject <= 1'b1;
                    end
                end else if (cnt != CNT_SAT) begin
                    cnt <= cnt + 1'b1;
                end
            end else if (fall && vpp_high) begin
                armed    <= 1'b1;
                cnt      <= CNT_W'(1);
                cap_addr <= addr;
                cap_data <= din;
            end
        end
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 erase,
    input  wr_req_t              wr_req,
    input  logic [EP_ADDR_W-1:0] rd_addr,
    output logic [EP_DATA_W-1:0] rd_data
);
    logic [EP_DATA_W-1:0] cells [EP_DEPTH];

    always_ff @(posedge clk) begin
        if (rst || erase) begin
            for (int i = 0; i < EP_DEPTH; i++) cells[i] <= '1;
        end else if (wr_req.valid) begin
            cells[wr_req.addr] <= cells[wr_req.addr] & wr_req.data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
    import eprom_pkg::*;
#(
    parameter longint CLK_HZ = 125_000_000,
    parameter longint PW_MIN_MS = 45,
    parameter longint PW_MAX_MS = 55,
    localparam longint MIN_CYC = ms_to_cycles(CLK_HZ, PW_MIN_MS),
    localparam longint MAX_CYC = ms_to_cycles(CLK_HZ, PW_MAX_MS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 erase,
    input  logic [EP_ADDR_W-1:0] addr,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 vpp_high,
    input  logic [EP_DATA_W-1:0] din,
    output logic [EP_DATA_W-1:0] dout,
    output logic                 dout_en,
    output logic                 prog_err
);
    mode_e   mode;
    logic    drive;
    wr_req_t wr_req;
    logic    reject;

    eprom_mode_dec u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .vpp_high (vpp_high),
        .mode     (mode),
        .drive    (drive)
    );

    eprom_pulse_qual #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .vpp_high (vpp_high),
        .addr     (addr),
        .din      (din),
        .wr_req   (wr_req),
        .reject   (reject)
    );

    eprom_array u_arr (
        .clk     (clk),
        .rst     (rst),
        .erase   (erase),
        .wr_req  (wr_req),
        .rd_addr (addr),
        .rd_data (dout)
    );

    assign dout_en  = drive && (mode != MODE_INHIBIT);
    assign prog_err = reject;
endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk
    import eprom_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 erase,
    input logic [EP_ADDR_W-1:0] addr,
    input logic                 ce_n,
    input logic                 oe_n,
    input logic                 vpp_high,
    input logic [EP_DATA_W-1:0] dout,
    input logic                 dout_en,
    input logic                 prog_err
);
    a_r3_standby_float: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !dout_en);

    a_r4_read_drives: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && !vpp_high) |-> dout_en);

    a_r5_quiet_float: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && oe_n) |-> !dout_en);

    a_r6_vpp_float: assert property (@(posedge clk) disable iff (rst)
        vpp_high |-> !dout_en);

    a_r1_erase_ones: assert property (@(posedge clk) disable iff (rst)
        $past(erase) |-> (dout == '1));

    a_r2_only_clears: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(erase) && $stable(addr)) |-> ((dout & ~$past(dout)) == '0));

    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
        prog_err |=> !prog_err);

    a_r8_err_after_rise: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> ($past(ce_n) && $past(vpp_high)));
endmodule

bind eprom_emu eprom_emu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .erase    (erase),
    .addr     (addr),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .vpp_high (vpp_high),
    .dout     (dout),
    .dout_en  (dout_en),
    .prog_err (prog_err)
);

// File: tb/eprom_emu_tb.sv
module eprom_emu_tb;
    localparam longint HZ   = 2000;
    localparam int     PMIN = 90;
    localparam int     PMAX = 110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        erase = 1'b0;
    logic [11:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        vpp_high = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        prog_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [4096];

    always #4 clk = ~clk;

    eprom_emu #(.CLK_HZ(HZ)) u_dut (
        .clk(clk), .rst(rst), .erase(erase), .addr(addr), .ce_n(ce_n),
        .oe_n(oe_n), .vpp_high(vpp_high), .din(din), .dout(dout),
        .dout_en(dout_en), .prog_err(prog_err)
    );

    function automatic bit in_win(input int len);
        return (len >= PMIN) && (len <= PMAX);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic read_chk(input logic [11:0] a, input string req);
        @(negedge clk);
        vpp_high = 0; ce_n = 0; oe_n = 0; addr = a;
        #1;
        chk(dout_en === 1'b1, req, dout_en, 1);
        chk(dout === model[a], req, dout, model[a]);
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic pulse(input logic [11:0] a, input logic [7:0] d, input int len,
                         input string req);
        bit good;
        good = in_win(len);
        @(negedge clk);
        addr = a; din = d; oe_n = 1; ce_n = 1; vpp_high = 1;
        @(negedge clk);
        ce_n = 0;
        repeat (len) @(negedge clk);
        ce_n = 1;
        @(negedge clk);
        chk(prog_err === !good, req, prog_err, !good);
        @(negedge clk);
        chk(prog_err === 1'b0, "R8 one-cycle", prog_err, 0);
        if (good) model[a] = model[a] & d;
        vpp_high = 0;
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state and R3 standby
        chk(dout_en === 1'b0, "R3 reset float", dout_en, 0);
        read_chk(12'h000, "R1 reset blank");
        read_chk(12'hFFF, "R1 reset blank top");
        @(negedge clk); ce_n = 1; oe_n = 0; #1;
        chk(dout_en === 1'b0, "R3 standby with oe low", dout_en, 0);
        @(negedge clk); ce_n = 0; oe_n = 1; #1;
        chk(dout_en === 1'b0, "R5 quiet with oe high", dout_en, 0);
        @(negedge clk); ce_n = 1; oe_n = 1;

        // R7 window boundaries
        pulse(12'h010, 8'h00, PMIN - 1, "R8 short reject");
        read_chk(12'h010, "R7 short no write");
        pulse(12'h011, 8'hA5, PMIN, "R7 min accept");
        read_chk(12'h011, "R7 min write");
        pulse(12'h012, 8'h5A, PMAX, "R7 max accept");
        read_chk(12'h012, "R7 max write");
        pulse(12'h013, 8'h00, PMAX + 1, "R8 long reject");
        read_chk(12'h013, "R7 long no write");

        // R2 clear-only
        pulse(12'h020, 8'hF0, 100, "R2 first");
        pulse(12'h020, 8'h3C, 100, "R2 second");
        read_chk(12'h020, "R2 and of writes");
        chk(model[12'h020] == 8'h30, "R2 model", model[12'h020], 8'h30);

        // R6 inhibit and vpp float
        @(negedge clk); addr = 12'h020; din = 8'h00; vpp_high = 1; ce_n = 1; oe_n = 0;
        repeat (120) @(negedge clk);
        chk(dout_en === 1'b0, "R6 inhibit float", dout_en, 0);
        ce_n = 0; #1;
        chk(dout_en === 1'b0, "R6 program float", dout_en, 0);
        ce_n = 1; vpp_high = 0;
        read_chk(12'h020, "R6 inhibit no change");

        // R9 level low before vpp
        @(negedge clk); addr = 12'h030; din = 8'h00; oe_n = 1; ce_n = 0;
        repeat (2) @(negedge clk);
        vpp_high = 1;
        repeat (100) @(negedge clk);
        ce_n = 1;
        @(negedge clk);
        chk(prog_err === 1'b0, "R9 steady level no err", prog_err, 0);
        vpp_high = 0;
        read_chk(12'h030, "R9 steady level no write");

        // R9 vpp dropped mid-pulse
        @(negedge clk); addr = 12'h031; din = 8'h00; vpp_high = 1;
        @(negedge clk); ce_n = 0;
        repeat (50) @(negedge clk);
        vpp_high = 0;
        repeat (50) @(negedge clk);
        ce_n = 1;
        @(negedge clk);
        chk(prog_err === 1'b0, "R9 abort no err", prog_err, 0);
        read_chk(12'h031, "R9 abort no write");

        // random mix around window edges
        for (int k = 0; k < 24; k++) begin
            logic [11:0] a;
            logic [7:0]  d;
            int          len;
            a   = 12'h100 + 12'($urandom % 6);
            d   = 8'($urandom);
            len = 86 + int'($urandom % 30);
            pulse(a, d, len, "R7 random window");
            read_chk(a, "R2 random readback");
        end

        // R1 erase
        @(negedge clk); erase = 1;
        @(negedge clk); erase = 0;
        for (int i = 0; i < 4096; i++) model[i] = 8'hFF;
        read_chk(12'h020, "R1 erase restores");
        read_chk(12'h011, "R1 erase restores");
        read_chk(12'h103, "R1 erase restores");

        summary();
    end
endmodule